// File: doc/BRIEF.md
# Row-Hit Tracking Command Queue

This block is a first-in first-out queue of DRAM access requests placed between an address generator and a DRAM command scheduler. Each request carries a bank, a row, a column and a read/write type. The queue marks each request with a flag that shows whether the next request goes to the same open row.

When a request is accepted, its bank and row are compared with the request stored most recently. If either differs, the stored request's flag is cleared. A fresh entry always starts with its flag set. At the head, a cleared flag means the access is to be issued with auto-precharge, so the row closes at the end of the burst. A set flag keeps the row open. The decision therefore comes from the request queued directly behind each one, not from a fixed policy or from history.

The scheduler takes the head through a valid/ready handshake. It sees a single auto-precharge bit beside the address fields. DRAM timing, data movement and refresh are handled elsewhere.

Top module: `rowHitCmdQueue`

## Requirements
- R1: Accepted requests leave the head in the order they were pushed. Each one keeps its bank (2 bits), row (12 bits), column (9 bits) and write bit (1 = write) unchanged.
- R2: A newly accepted entry starts with its hit flag set. An entry that reaches the head while it is still the newest entry is presented with headAutoPre = 0.
- R3: headAutoPre is 1 for a head entry whose successor in the queue has a different bank or a different row.
- R4: A successor with the same bank and the same row, whether or not its column differs, leaves the earlier entry's headAutoPre at 0.
- R5: The queue holds up to DEPTH entries (default 8). full is 1 exactly when DEPTH entries are held, and empty is 1 exactly when none are held.
- R6: A push while full is ignored. The queue contents, the head and the newest entry's flag are all unchanged, and overflow is set and stays 1 until reset.
- R7: headValid is 1 whenever the queue is not empty. A pop happens only on a cycle where headValid and headReady are both 1. While headReady is 0, the head fields stay the same.
- R8: A push and a pop may happen in the same cycle. The push is compared with the newest entry as it stood before that cycle. If that entry is the head being popped, it is issued with headAutoPre = 0.
- R9: After reset the queue is empty, headValid and headAutoPre are 0, and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushValid | input | 1 | Request offered this cycle |
| pushBank | input | 2 | Bank of the offered request |
| pushRow | input | 12 | Row of the offered request |
| pushCol | input | 9 | Column of the offered request |
| pushWrite | input | 1 | 1 = write, 0 = read |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| overflow | output | 1 | Sticky: a push was offered while full |
| headValid | output | 1 | Head entry present |
| headReady | input | 1 | Scheduler takes the head this cycle |
| headBank | output | 2 | Bank of the head entry |
| headRow | output | 12 | Row of the head entry |
| headCol | output | 9 | Column of the head entry |
| headWrite | output | 1 | Type of the head entry |
| headAutoPre | output | 1 | Issue the head access with auto-precharge |

## Verification
On every cycle the assertions check several things. full and empty are never both set. The overflow flag is raised by a push into a full queue and then stays set. A push without a pop leaves the queue non-empty. The head fields hold still while the scheduler stalls. Only the bench's reference model can show that the auto-precharge bit matches the real successor relation under every order of pushes and pops. The scenarios cover same-row runs, bank changes, row changes, a push into a full queue, and a push and pop together on a single entry. They also confirm the FIFO ordering of the stored fields.

// File: rtl/rowhit_pkg.sv
package rowhit_pkg;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 9;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              isWrite;
  } cmdEntry_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic pushEn;
    logic popEn;
    logic hasNewest;
  } qStrobe_t;
endpackage

// File: rtl/rowHitCtrl.sv
module rowHitCtrl
  import rowhit_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic pushValid,
  input  logic headReady,
  output qStrobe_t strb,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wrIdx,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rdIdx,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] lastIdx,
  output logic full,
  output logic empty,
  output logic overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  always_comb begin
    strb.pushEn    = pushValid && !full;
    strb.popEn     = !empty && headReady;
    strb.hasNewest = !empty;
    lastIdx        = (wrIdx == '0) ? LAST_SLOT : wrIdx - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      rdIdx    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (strb.pushEn) wrIdx <= bump(wrIdx);
      if (strb.popEn)  rdIdx <= bump(rdIdx);
      if (strb.pushEn && !strb.popEn)      count <= count + 1'b1;
      else if (!strb.pushEn && strb.popEn) count <= count - 1'b1;
      if (pushValid && full) overflow <= 1'b1;
    end
  end

  // R5
  full_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  // R5
  fill_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushEn && !strb.popEn) |=> !empty);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid) |=> overflow);
  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

// File: rtl/rowHitData.sv
module rowHitData
  import rowhit_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  qStrobe_t strb,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wrIdx,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rdIdx,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] lastIdx,
  input  cmdEntry_t pushCmd,
  output cmdEntry_t headCmd,
  output logic headHit
);
  cmdEntry_t        slots [DEPTH];
  logic [DEPTH-1:0] hitFlag;
  logic             rowChange;

  // compare against the newest entry as it stands before this cycle's push
  assign rowChange = (slots[lastIdx].bank != pushCmd.bank) ||
                     (slots[lastIdx].row  != pushCmd.row);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.pushEn && wrIdx == i) slots[i] <= pushCmd;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hitFlag[i] <= 1'b1;
        end else if (strb.pushEn && wrIdx == i) begin
          hitFlag[i] <= 1'b1;
        end else if (strb.pushEn && strb.hasNewest && lastIdx == i && rowChange) begin
          hitFlag[i] <= 1'b0;
        end
      end
    end
  endgenerate

  assign headCmd = slots[rdIdx];
  assign headHit = hitFlag[rdIdx];

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hasNewest && !strb.popEn) |=> $stable(headCmd));
endmodule

// File: rtl/rowHitCmdQueue.sv
module rowHitCmdQueue
  import rowhit_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic [1:0]  pushBank,
  input  logic [11:0] pushRow,
  input  logic [8:0]  pushCol,
  input  logic        pushWrite,
  output logic        full,
  output logic        empty,
  output logic        overflow,
  output logic        headValid,
  input  logic        headReady,
  output logic [1:0]  headBank,
  output logic [11:0] headRow,
  output logic [8:0]  headCol,
  output logic        headWrite,
  output logic        headAutoPre
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  qStrobe_t   strb;
  logic [PTR_W-1:0] wrIdx, rdIdx, lastIdx;
  cmdEntry_t  pushCmd, headCmd;
  logic       headHit;

  assign pushCmd = '{bank: pushBank, row: pushRow, col: pushCol, isWrite: pushWrite};

  rowHitCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .headReady(headReady),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .lastIdx(lastIdx),
    .full(full), .empty(empty), .overflow(overflow)
  );

  rowHitData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .lastIdx(lastIdx), .pushCmd(pushCmd), .headCmd(headCmd), .headHit(headHit)
  );

  assign headValid   = !empty;
  assign headBank    = headCmd.bank;
  assign headRow     = headCmd.row;
  assign headCol     = headCmd.col;
  assign headWrite   = headCmd.isWrite;
  assign headAutoPre = headValid && !headHit;
endmodule

// File: tb/tb_rowHitCmdQueue.sv
module tb_rowHitCmdQueue;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, pushWrite = 1'b0, headReady = 1'b0;
  logic [1:0]  pushBank = '0;
  logic [11:0] pushRow = '0;
  logic [8:0]  pushCol = '0;
  logic full, empty, overflow, headValid, headWrite, headAutoPre;
  logic [1:0]  headBank;
  logic [11:0] headRow;
  logic [8:0]  headCol;

  always #2 clk = ~clk;

  rowHitCmdQueue #(.DEPTH(DEPTH)) dut (.*);

  int vecCount = 0;
  int errCount = 0;

  // reference model: packed {bank,row,col,write} and a flag per entry
  logic [23:0] mq[$];
  bit          mf[$];
  bit          mOvf = 0;

  task automatic chk(input string req, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit hv;
    hv = (mq.size() > 0);
    chk("R7 headValid", headValid, hv);
    chk("R5 full", full, mq.size() == DEPTH);
    chk("R5 empty", empty, mq.size() == 0);
    chk("R6 overflow", overflow, mOvf);
    if (hv) begin
      chk("R1 head fields", {headBank, headRow, headCol, headWrite}, mq[0]);
      chk("R2 R3 R4 R8 headAutoPre", headAutoPre, !mf[0]);
    end else begin
      chk("R9 headAutoPre idle", headAutoPre, 0);
    end
  endtask

  task automatic step(input bit pv, input int b, input int r, input int c,
                      input bit w, input bit rdy);
    bit doPop, doPush;
    pushValid = pv; pushBank = 2'(b); pushRow = 12'(r); pushCol = 9'(c);
    pushWrite = w; headReady = rdy;
    @(posedge clk);
    doPop  = (mq.size() > 0) && rdy;
    doPush = pv && (mq.size() < DEPTH);
    if (pv && mq.size() == DEPTH) mOvf = 1;
    if (doPush && mq.size() > 0) begin
      if (mq[$][23:22] != 2'(b) || mq[$][21:10] != 12'(r)) mf[mf.size()-1] = 0;
    end
    if (doPop) begin
      void'(mq.pop_front());
      void'(mf.pop_front());
    end
    if (doPush) begin
      mq.push_back({2'(b), 12'(r), 9'(c), w});
      mf.push_back(1);
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #400000;
    errCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    compareAll();
    rstN = 1'b1;
    @(negedge clk);
    compareAll();

    // R4: same bank and row, columns change
    for (int i = 0; i < 4; i++) step(1, 1, 7, i * 3, i[0], 0);
    // R3: row change, then bank change with same row
    step(1, 1, 8, 0, 0, 0);
    step(1, 2, 8, 0, 1, 0);
    // R7: drain with ready toggling
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, i[0]);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1);

    // R8: single entry, push and pop together
    step(1, 0, 5, 1, 0, 0);
    step(1, 3, 9, 2, 1, 1);
    step(1, 3, 9, 4, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);

    // R5 R6: fill, then push into full queue with a row change
    for (int i = 0; i < DEPTH; i++) step(1, 0, 4, i, 0, 0);
    step(1, 2, 100, 5, 1, 0);
    step(1, 2, 100, 6, 1, 1);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 1);

    // random mix with a small address range to get frequent hits
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, $urandom % 2, $urandom % 2, $urandom % 512,
           $urandom % 2, ($urandom % 2) == 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule